// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs clause-22 management transactions towards an Ethernet PHY over a management clock pin and a shared bidirectional data pin. Software starts a transaction with a single write of a packed 32-bit frame word. The block then sends a run of preamble ones followed by the frame, most significant bit first. For a read it releases the data pin from the turnaround onwards and collects the sixteen bits that the PHY returns.

When the transaction ends, any read data replaces the low half of the stored frame word and a sticky completion flag rises. The expected use is: clear the flag by writing one to it, write the frame word, poll the flag, then read the frame word back. A separate speed register sets the management clock period as 2*(speed+1) system clocks. A speed of zero keeps the block from starting.

Top module: `mdio_frame_master`

## Requirements
- R1: After reset the management clock is low, the data pin is released (`mdio_oe`=0), `busy` and `evt` are 0, and the frame and speed registers read zero.
- R2: While a transaction runs, each high phase and each low phase of `mdc` lasts speed+1 system clocks, starting with a low phase. While idle, `mdc` stays low.
- R3: `evt` stays set until a cycle with `evt_clr`=1 clears it. If a completion and a clear fall in the same cycle, the completion wins.
- R4: A frame write while idle with a nonzero speed starts a transaction that sends 32 ones, then frame bits 31 down to 0. The frame fields are: bits 31:30 start (01), 29:28 opcode, 27:23 PHY address, 22:18 register address, 17:16 turnaround, 15:0 data.
- R5: `mdio_o` changes only together with a falling `mdc` edge (or at the start) and is stable when `mdc` rises.
- R6: With opcode 10 (read), `mdio_oe` is 0 from the first turnaround bit (bit 46 of the 64) to the end. With any other opcode, including 01 (write), all 64 bits are driven.
- R7: For a read, the data pin is sampled on the 16 rising `mdc` edges of the data phase, first sample into bit 15. On completion these samples replace frame bits 15:0, and bits 31:16 are kept.
- R8: Completion comes 128*(speed+1) clocks after the clock edge that took the frame write. At that edge `busy` falls and `evt` is set.
- R9: A frame write while `busy` is 1 is ignored. The frame and the transaction continue unchanged.
- R10: A frame write while the speed register is zero is ignored: no transaction starts and the frame register keeps its value.
- R11: A speed write while `busy` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_we | input | 1 | Frame register write strobe (starts a transaction) |
| frame_wd | input | 32 | Frame word to write |
| frame_q | output | 32 | Frame register contents |
| speed_we | input | 1 | Speed register write strobe |
| speed_wd | input | SPD_W | Speed value to write |
| speed_q | output | SPD_W | Speed register contents |
| evt_clr | input | 1 | Write-one-to-clear of the completion flag |
| evt | output | 1 | Completion flag |
| busy | output | 1 | Transaction in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data pin output value |
| mdio_oe | output | 1 | Data pin output enable |
| mdio_i | input | 1 | Data pin input value |

## Verification
The bench measures the exact clock count from the frame write to completion, and the length of the first low and high `mdc` phases. A divider that is off by one gives wrong counts in both measurements. It compares every driven bit and every enable bit against the frame word. A read that releases the pin one bit late, or a sampling point shifted by one edge, shows up as a wrong turnaround bit or as read data rotated by one bit. Frame and speed writes made during a transaction, and a frame write while the speed is zero, are checked through the register readback and the final frame. A design that accepted such a write would corrupt the frame or start a transaction it should not start.

// File: rtl/mdio_frame_master.sv
module mdio_frame_master #(
  parameter int SPD_W   = 6,
  parameter int PRE_LEN = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_we,
  input  logic [31:0]      frame_wd,
  output logic [31:0]      frame_q,
  input  logic             speed_we,
  input  logic [SPD_W-1:0] speed_wd,
  output logic [SPD_W-1:0] speed_q,
  input  logic             evt_clr,
  output logic             evt,
  output logic             busy,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i
);
  localparam int TOT   = PRE_LEN + 32;
  localparam int CNT_W = $clog2(TOT);

  logic [SPD_W-1:0] div;
  logic [CNT_W-1:0] bitn;
  logic [CNT_W-1:0] fpos;
  logic [15:0]      cap;

  wire is_rd = (frame_q[29:28] == 2'b10);
  wire start = frame_we && !busy && (speed_q != '0);
  wire half  = busy && (div == speed_q);
  wire rise  = half && !mdc;
  wire fall  = half && mdc;
  wire last  = (bitn == CNT_W'(TOT - 1));
  wire in_pre = (bitn < CNT_W'(PRE_LEN));

  assign fpos    = CNT_W'(TOT - 1) - bitn;
  assign mdio_o  = busy && (in_pre || frame_q[fpos[4:0]]);
  assign mdio_oe = busy && !(is_rd && (bitn >= CNT_W'(TOT - 18)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      speed_q <= '0;
      busy    <= 1'b0;
      mdc     <= 1'b0;
      div     <= '0;
      bitn    <= '0;
      cap     <= '0;
    end else begin
      if (speed_we && !busy)
        speed_q <= speed_wd;
      if (start) begin
        frame_q <= frame_wd;
        busy    <= 1'b1;
        mdc     <= 1'b0;
        div     <= '0;
        bitn    <= '0;
      end else if (busy) begin
        if (half) begin
          div <= '0;
          mdc <= ~mdc;
        end else begin
          div <= div + 1'b1;
        end
        if (rise && is_rd && (bitn >= CNT_W'(TOT - 16)))
          cap <= {cap[14:0], mdio_i};
        if (fall) begin
          if (last) begin
            busy <= 1'b0;
            if (is_rd)
              frame_q[15:0] <= cap;
          end else begin
            bitn <= bitn + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      evt <= 1'b0;
    else if (fall && last)
      evt <= 1'b1;
    else if (evt_clr)
      evt <= 1'b0;
  end
endmodule

// File: rtl/mdio_frame_master_chk.sv
module mdio_frame_master_chk #(
  parameter int SPD_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [31:0]      frame_q,
  input logic [SPD_W-1:0] speed_q,
  input logic             evt_clr,
  input logic             evt,
  input logic             busy,
  input logic             mdc,
  input logic             mdio_o,
  input logic             mdio_oe
);
  a_r2_idle_mdc_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  a_r5_stable_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $rose(mdc) |-> $stable(mdio_o));

  a_r6_write_drives: assert property (@(posedge clk) disable iff (!rst_n)
    busy && frame_q[29:28] == 2'b01 |-> mdio_oe);

  a_r8_evt_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> evt);

  a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $past(evt_clr) && !$fell(busy) |-> !evt);

  a_r9_frame_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(frame_q));

  a_r11_speed_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(speed_q));

  a_r10_zero_speed: assert property (@(posedge clk) disable iff (!rst_n)
    speed_q == '0 && !busy |=> !busy);
endmodule

bind mdio_frame_master mdio_frame_master_chk #(.SPD_W(SPD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_q(frame_q), .speed_q(speed_q),
  .evt_clr(evt_clr), .evt(evt), .busy(busy), .mdc(mdc),
  .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/mdio_frame_master_test.sv
module mdio_frame_master_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_we = 1'b0;
  logic [31:0] frame_wd = '0;
  logic        speed_we = 1'b0;
  logic [5:0]  speed_wd = '0;
  logic        evt_clr = 1'b0;
  wire  [31:0] frame_q;
  wire  [5:0]  speed_q;
  wire         evt, busy, mdc, mdio_o, mdio_oe;
  logic        phy_en = 1'b0;
  logic        phy_val = 1'b0;
  wire         mdio_line = mdio_oe ? mdio_o : (phy_en ? phy_val : 1'b1);

  int checks = 0;
  int fails  = 0;
  int idx    = 0;
  logic        cur_read = 1'b0;
  logic [15:0] cur_phy = '0;
  logic [63:0] got_bits, got_oe;

  always #5 clk = ~clk;

  mdio_frame_master uut (
    .clk(clk), .rst_n(rst_n), .frame_we(frame_we), .frame_wd(frame_wd),
    .frame_q(frame_q), .speed_we(speed_we), .speed_wd(speed_wd),
    .speed_q(speed_q), .evt_clr(evt_clr), .evt(evt), .busy(busy),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_line)
  );

  always @(posedge mdc) begin
    if (idx < 64) begin
      got_bits[idx] = mdio_line;
      got_oe[idx]   = mdio_oe;
    end
    idx = idx + 1;
  end

  always @(negedge mdc) begin
    if (cur_read && idx == 47) begin
      phy_en = 1'b1; phy_val = 1'b0;
    end else if (cur_read && idx >= 48 && idx <= 63) begin
      phy_en = 1'b1; phy_val = cur_phy[63 - idx];
    end else begin
      phy_en = 1'b0;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_speed(input logic [5:0] s);
    speed_we = 1'b1; speed_wd = s;
    @(negedge clk); speed_we = 1'b0;
  endtask

  task automatic clear_evt();
    evt_clr = 1'b1;
    @(negedge clk); evt_clr = 1'b0;
  endtask

  task automatic launch(input logic [31:0] fr, input logic [15:0] ph);
    cur_read = (fr[29:28] == 2'b10);
    cur_phy = ph;
    idx = 0;
    got_bits = '0;
    got_oe = '0;
    frame_we = 1'b1; frame_wd = fr;
    @(negedge clk); frame_we = 1'b0;
  endtask

  task automatic wait_evt(output int n);
    n = 0;
    while (!evt && n < 100000) begin
      @(negedge clk); n++;
    end
  endtask

  localparam logic [53:0] VEC [5] = '{
    {6'd1, 32'h5192ABCD, 16'h0000},
    {6'd2, 32'h608A0000, 16'h1234},
    {6'd1, 32'h6FFEFFFF, 16'h8001},
    {6'd3, 32'h5AAA0000, 16'h0000},
    {6'd1, 32'h4000FFFF, 16'h5555}
  };

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int n;
    logic [63:0] eb, eo, mask;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 outputs", {58'd0, mdc, mdio_oe, busy, evt, 2'b00}, 64'd0);
    chk("R1 regs", {26'd0, speed_q, frame_q}, 64'd0);

    launch(32'h5192ABCD, 16'h0);
    repeat (20) @(negedge clk);
    chk("R10 busy", {63'd0, busy}, 64'd0);
    chk("R10 frame", {32'd0, frame_q}, 64'd0);
    chk("R2 idle mdc", {63'd0, mdc}, 64'd0);

    for (int v = 0; v < 5; v++) begin
      logic [5:0]  s;
      logic [31:0] fr, ef;
      logic [15:0] ph;
      s = VEC[v][53:48]; fr = VEC[v][47:16]; ph = VEC[v][15:0];
      set_speed(s);
      clear_evt();
      launch(fr, ph);
      wait_evt(n);
      for (int i = 0; i < 64; i++) begin
        eb[i] = (i < 32) ? 1'b1 : fr[63 - i];
        eo[i] = !((fr[29:28] == 2'b10) && i >= 46);
      end
      mask = (fr[29:28] == 2'b10) ? 64'h0000_3FFF_FFFF_FFFF : '1;
      ef = (fr[29:28] == 2'b10) ? {fr[31:16], ph} : fr;
      chk("R8 cycles", 64'(n), 64'(128 * (s + 1)));
      chk("R8 busy", {63'd0, busy}, 64'd0);
      chk("R4,R5 bits", got_bits & mask, eb & mask);
      chk("R6 oe", got_oe, eo);
      chk("R7 frame", {32'd0, frame_q}, {32'd0, ef});
    end

    set_speed(6'd3);
    clear_evt();
    launch(32'h5192ABCD, 16'h0);
    n = 0;
    while (!mdc && n < 100) begin @(negedge clk); n++; end
    chk("R2 low phase", 64'(n), 64'd4);
    while (mdc && n < 100) begin @(negedge clk); n++; end
    chk("R2 full period", 64'(n), 64'd8);
    frame_we = 1'b1; frame_wd = 32'h60000000;
    speed_we = 1'b1; speed_wd = 6'd7;
    @(negedge clk);
    frame_we = 1'b0; speed_we = 1'b0;
    chk("R11 speed", 64'(speed_q), 64'd3);
    chk("R9 frame busy", {32'd0, frame_q}, 64'h5192ABCD);
    wait_evt(n);
    chk("R9 frame end", {32'd0, frame_q}, 64'h5192ABCD);
    repeat (3) @(negedge clk);
    chk("R3 sticky", {63'd0, evt}, 64'd1);
    clear_evt();
    chk("R3 cleared", {63'd0, evt}, 64'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule